// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block sits between a simple request port on the processor side and a small behavioural DRAM array held inside the block. The array is a grid of multi-bit cells. Each request word address is divided into a row part and a column part. Both parts travel over one narrow strobed address bus, one after the other. The row strobe carries the row index and copies that whole row into an internal row buffer. The column strobe then carries the column index and moves one cell between the row buffer and the data lines.

After an access, the controller leaves the row open. A later access to the same row therefore issues only a column strobe. An access to a different row first closes the open row with a precharge strobe, waits out the precharge time, and then opens the new row. A refresh timer counts the retention window, which is given in milliseconds and converted to clock cycles. From that count it asks for one row refresh per slot, visiting the rows in a round-robin order. A pending refresh waits until the current access has finished, then takes precedence over new requests, and leaves no row open.

Top module: `dram_ctrl`

## Requirements
- R1: After reset, the controller has no open row and every cell reads zero. In the first cycle after reset `req_ready_o` is high and `rsp_valid_o`, `ras_o`, `cas_o` and `pre_o` are low.
- R2: The request address takes the row index from bits [3:2] and the column index from bits [1:0]. A row strobe drives the row index on `mem_addr_o`. A column strobe drives the column index on `mem_addr_o`.
- R3: A read accepted while no row is open gives one row strobe in the cycle after acceptance. The column strobe follows T_RCD cycles after the row strobe. `rsp_valid_o` is high T_RCD+2 cycles after the accepting edge.
- R4: A read to the row that is already open gives no row strobe. The column strobe comes in the cycle after acceptance, and `rsp_valid_o` is high 2 cycles after the accepting edge.
- R5: A read to a row other than the open one gives a precharge strobe in the cycle after acceptance. The row strobe follows T_RP cycles later, and `rsp_valid_o` is high T_RP+T_RCD+2 cycles after the accepting edge.
- R6: A write raises `mem_we_o` together with its column strobe. It updates the addressed cell, so a later read returns the written value. A write never raises `rsp_valid_o`.
- R7: A request is taken on an edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low until that access has finished. `rsp_valid_o` is a pulse one cycle long.
- R8: A refresh is marked by `refresh_o` together with a row strobe. Refreshes visit rows 0,1,2,3 in turn. The gap between two refreshes is never more than the per-row interval plus 2*T_RP+T_RCD+4 cycles. The per-row interval is CLK_KHZ*REF_MS/ROWS cycles.
- R9: A pending refresh never interrupts an access in progress. It is served before any new request. After a refresh no row is open, so the next read pays the R3 latency.
- R10: `ras_o`, `cas_o` and `pre_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid, held until accepted |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | Word address {row, column} |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | One-cycle read data valid |
| rsp_rdata_o | output | 8 | Read data |
| ras_o | output | 1 | Row strobe pulse |
| cas_o | output | 1 | Column strobe pulse |
| pre_o | output | 1 | Precharge (row close) pulse |
| mem_we_o | output | 1 | Write enable, valid with the column strobe |
| mem_addr_o | output | 2 | Multiplexed row/column address |
| refresh_o | output | 1 | Marks a row strobe that is a refresh |

## Verification
The assertions check on every cycle that the strobes are mutually exclusive, and that the first strobe after acceptance is the right one for a page hit, an empty row buffer or a row conflict. They also check that the response is a single pulse, that `req_ready_o` drops after acceptance, that a column strobe occurs only with an open row, and that a pending refresh is taken before any new request. Only the bench scenarios can show the end-to-end latencies and whether the data read back is correct after mixed writes. The same holds for the round-robin refresh order, the refresh spacing, and the closed-row latency after a refresh. The bench checks these against its own model of the open row and the memory contents.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_ACT,
    S_COL,
    S_RPRE,
    S_RACT,
    S_RCLS
  } seq_state_e;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int INTERVAL = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic due_o
);
  localparam int TW = $clog2(INTERVAL) + 1;

  logic [TW-1:0] cnt_q;
  logic          due_q;
  logic          wrap;

  assign wrap  = cnt_q == TW'(INTERVAL - 1);
  assign due_o = due_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      due_q <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap)       due_q <= 1'b1;
      else if (ack_i) due_q <= 1'b0;
    end
  end

  // pending refresh is kept until served
  assert_due_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (due_q && !ack_i) |=> due_q);
endmodule

// File: rtl/dram_array.sv
module dram_array #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8,
  parameter int AW   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_i,
  input  logic          cas_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);

  logic [DW-1:0] cells_q [ROWS*COLS];
  logic [DW-1:0] rowbuf_q [COLS];
  logic [RW-1:0] buf_row_q;
  logic [DW-1:0] rdata_q;
  logic [RW-1:0] sel_row;
  logic [CW-1:0] sel_col;

  assign sel_row = addr_i[RW-1:0];
  assign sel_col = addr_i[CW-1:0];
  assign rdata_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ROWS*COLS; i++) cells_q[i] <= '0;
      for (int c = 0; c < COLS; c++) rowbuf_q[c] <= '0;
      buf_row_q <= '0;
      rdata_q   <= '0;
    end else begin
      if (ras_i) begin
        for (int c = 0; c < COLS; c++) rowbuf_q[c] <= cells_q[{sel_row, CW'(c)}];
        buf_row_q <= sel_row;
      end else if (cas_i && we_i) begin
        // write-through: array and row buffer both updated
        cells_q[{buf_row_q, sel_col}] <= wdata_i;
        rowbuf_q[sel_col]             <= wdata_i;
      end else if (cas_i) begin
        rdata_q <= rowbuf_q[sel_col];
      end
    end
  end

  assert_one_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ras_i && cas_i));
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctrl_pkg::*;
#(
  parameter int RW    = 2,
  parameter int CW    = 2,
  parameter int AW    = 2,
  parameter int DW    = 8,
  parameter int T_RCD = 2,
  parameter int T_RP  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            req_write_i,
  input  logic [RW+CW-1:0] req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  output logic            req_ready_o,
  input  logic            ref_due_i,
  output logic            ref_ack_o,
  output logic            ras_o,
  output logic            cas_o,
  output logic            pre_o,
  output logic            we_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   wdata_o,
  output logic            rsp_valid_o
);
  localparam int TMAX  = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int CNT_W = $clog2(TMAX + 1) + 1;

  seq_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic [RW-1:0]  row_q, open_row_q, ref_row_q, req_row;
  logic [CW-1:0]  col_q, req_col;
  logic           wr_q, open_vld_q, rsp_q;
  logic [DW-1:0]  wdata_q;
  logic           accept, hit, first, last_rcd, last_rp;

  assign req_row  = req_addr_i[RW+CW-1:CW];
  assign req_col  = req_addr_i[CW-1:0];
  assign req_ready_o = (state_q == S_IDLE) && !ref_due_i;
  assign accept   = req_valid_i && req_ready_o;
  assign hit      = open_vld_q && (open_row_q == req_row);
  assign first    = cnt_q == '0;
  assign last_rcd = cnt_q == CNT_W'(T_RCD - 1);
  assign last_rp  = cnt_q == CNT_W'(T_RP - 1);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (ref_due_i)        state_d = open_vld_q ? S_RPRE : S_RACT;
        else if (req_valid_i) state_d = hit ? S_COL : (open_vld_q ? S_PRE : S_ACT);
      end
      S_PRE:  if (last_rp)  state_d = S_ACT;
      S_ACT:  if (last_rcd) state_d = S_COL;
      S_COL:  state_d = S_IDLE;
      S_RPRE: if (last_rp)  state_d = S_RACT;
      S_RACT: if (last_rcd) state_d = S_RCLS;
      S_RCLS: if (last_rp)  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      row_q      <= '0;
      col_q      <= '0;
      wr_q       <= 1'b0;
      wdata_q    <= '0;
      open_row_q <= '0;
      open_vld_q <= 1'b0;
      ref_row_q  <= '0;
      rsp_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
      rsp_q   <= (state_q == S_COL) && !wr_q;
      if (accept) begin
        row_q   <= req_row;
        col_q   <= req_col;
        wr_q    <= req_write_i;
        wdata_q <= req_wdata_i;
      end
      if (state_q == S_ACT && first) begin
        open_row_q <= row_q;
        open_vld_q <= 1'b1;
      end
      if ((state_q == S_PRE || state_q == S_RPRE) && first) open_vld_q <= 1'b0;
      if (state_q == S_RACT && first) ref_row_q <= ref_row_q + 1'b1;
    end
  end

  always_comb begin
    ras_o  = (state_q == S_ACT || state_q == S_RACT) && first;
    cas_o  = state_q == S_COL;
    pre_o  = (state_q == S_PRE || state_q == S_RPRE || state_q == S_RCLS) && first;
    we_o   = cas_o && wr_q;
    ref_ack_o = (state_q == S_RACT) && first;
    unique case (state_q)
      S_ACT:   addr_o = AW'(row_q);
      S_RACT:  addr_o = AW'(ref_row_q);
      S_COL:   addr_o = AW'(col_q);
      default: addr_o = '0;
    endcase
  end

  assign wdata_o     = wdata_q;
  assign rsp_valid_o = rsp_q;

  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ras_o, cas_o, pre_o}));
  assert_empty_opens_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !open_vld_q) |=> (ras_o && !cas_o));
  assert_cas_needs_row_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_o |-> open_vld_q);
  assert_hit_col_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit) |=> (cas_o && !ras_o));
  assert_conflict_pre_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && open_vld_q && !hit) |=> pre_o);
  assert_busy_after_take_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);
  assert_rsp_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_ref_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && ref_due_i) |=> (state_q == S_RPRE || state_q == S_RACT));
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int ROWS    = 4,
  parameter int COLS    = 4,
  parameter int DW      = 8,
  parameter int T_RCD   = 2,
  parameter int T_RP    = 2,
  parameter int CLK_KHZ = 200000,
  parameter int REF_MS  = 10
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 req_valid_i,
  output logic                                 req_ready_o,
  input  logic                                 req_write_i,
  input  logic [$clog2(ROWS)+$clog2(COLS)-1:0] req_addr_i,
  input  logic [DW-1:0]                        req_wdata_i,
  output logic                                 rsp_valid_o,
  output logic [DW-1:0]                        rsp_rdata_o,
  output logic                                 ras_o,
  output logic                                 cas_o,
  output logic                                 pre_o,
  output logic                                 mem_we_o,
  output logic [(($clog2(ROWS) > $clog2(COLS)) ? $clog2(ROWS) : $clog2(COLS))-1:0] mem_addr_o,
  output logic                                 refresh_o
);
  localparam int RW       = $clog2(ROWS);
  localparam int CW       = $clog2(COLS);
  localparam int AW       = (RW > CW) ? RW : CW;
  localparam int INTERVAL = CLK_KHZ * REF_MS / ROWS;

  logic          ref_due, ref_ack;
  logic [DW-1:0] wdata_bus;

  dram_ref_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ack_i (ref_ack),
    .due_o (ref_due)
  );

  dram_seq #(
    .RW(RW), .CW(CW), .AW(AW), .DW(DW), .T_RCD(T_RCD), .T_RP(T_RP)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .req_ready_o(req_ready_o),
    .ref_due_i  (ref_due),
    .ref_ack_o  (ref_ack),
    .ras_o      (ras_o),
    .cas_o      (cas_o),
    .pre_o      (pre_o),
    .we_o       (mem_we_o),
    .addr_o     (mem_addr_o),
    .wdata_o    (wdata_bus),
    .rsp_valid_o(rsp_valid_o)
  );

  dram_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .AW(AW)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ras_i  (ras_o),
    .cas_i  (cas_o),
    .we_i   (mem_we_o),
    .addr_i (mem_addr_o),
    .wdata_i(wdata_bus),
    .rdata_o(rsp_rdata_o)
  );

  assign refresh_o = ref_ack;
endmodule

// File: tb/dram_ctrl_test.sv
`timescale 1ns/1ps
module dram_ctrl_test;
  localparam int T_RCD = 2;
  localparam int T_RP  = 3;
  localparam int CLK_KHZ = 40;
  localparam int REF_MS  = 10;
  localparam int REF_INT = CLK_KHZ * REF_MS / 4;
  localparam int REF_BOUND = REF_INT + 2*T_RP + T_RCD + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready_o, rsp_valid_o, ras_o, cas_o, pre_o, mem_we_o, refresh_o;
  logic [7:0] rsp_rdata_o;
  logic [1:0] mem_addr_o;

  int checks = 0, errors = 0, cyc = 0;
  int ras_cnt = 0, ref_cnt = 0, last_ref = 0, exp_ref_row = 0;
  int cur_row = 0, cur_col = 0;
  bit cur_wr = 0, m_open = 0;
  int m_row = 0;
  logic [7:0] mem [16];

  dram_ctrl #(.T_RCD(T_RCD), .T_RP(T_RP), .CLK_KHZ(CLK_KHZ), .REF_MS(REF_MS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .ras_o(ras_o), .cas_o(cas_o),
    .pre_o(pre_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .refresh_o(refresh_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // strobe monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (ras_o || cas_o || pre_o)
        chk(int'(ras_o) + int'(cas_o) + int'(pre_o) <= 1, "R10 strobe overlap",
            int'(ras_o) + int'(cas_o) + int'(pre_o), 1);
      if (refresh_o) begin
        chk(int'(mem_addr_o) == exp_ref_row, "R8 refresh row", int'(mem_addr_o), exp_ref_row);
        chk(cyc - last_ref <= REF_BOUND, "R8 refresh gap", cyc - last_ref, REF_BOUND);
        exp_ref_row = (exp_ref_row + 1) % 4;
        last_ref = cyc;
        ref_cnt++;
        m_open = 0;
      end else if (ras_o) begin
        ras_cnt++;
        chk(int'(mem_addr_o) == cur_row, "R2 row address", int'(mem_addr_o), cur_row);
      end
      if (cas_o) begin
        chk(int'(mem_addr_o) == cur_col, "R2 column address", int'(mem_addr_o), cur_col);
        chk(mem_we_o == cur_wr, "R6 write enable", int'(mem_we_o), int'(cur_wr));
      end
    end
  end

  task automatic do_req(bit wr, int addr, int data, string tag_override);
    int row = addr >> 2;
    int col = addr & 3;
    int exp_lat, exp_ras, k, ras0;
    string tag;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 4'(addr); req_wdata = 8'(data);
    while (!req_ready_o) @(negedge clk);
    if (m_open && m_row == row) begin exp_lat = 2; exp_ras = 0; tag = "R4 page hit"; end
    else if (m_open) begin exp_lat = T_RP + T_RCD + 2; exp_ras = 1; tag = "R5 row conflict"; end
    else begin exp_lat = T_RCD + 2; exp_ras = 1; tag = "R3 closed row"; end
    if (tag_override != "") tag = tag_override;
    cur_row = row; cur_col = col; cur_wr = wr;
    ras0 = ras_cnt; k = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready_o, "R7 ready drops", int'(req_ready_o), 0);
    if (!wr) begin
      while (!rsp_valid_o && cyc - k < 60) @(negedge clk);
      chk(cyc - k == exp_lat, tag, cyc - k, exp_lat);
      chk(rsp_rdata_o == mem[addr], "R6 read data", int'(rsp_rdata_o), int'(mem[addr]));
      @(negedge clk);
      chk(!rsp_valid_o, "R7 response pulse", int'(rsp_valid_o), 0);
    end else begin
      while (!cas_o && cyc - k < 60) @(negedge clk);
      chk(cyc - k == exp_lat - 1, tag, cyc - k + 1, exp_lat);
      @(negedge clk);
      chk(!rsp_valid_o, "R6 no response on write", int'(rsp_valid_o), 0);
      mem[addr] = 8'(data);
    end
    chk(ras_cnt - ras0 == exp_ras, "R4 row strobes", ras_cnt - ras0, exp_ras);
    m_open = 1; m_row = row;
  endtask

  initial begin
    int seed;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    last_ref = cyc;
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R1 ready after reset", int'(req_ready_o), 1);
    chk(!rsp_valid_o && !ras_o && !cas_o && !pre_o, "R1 quiet outputs",
        int'({rsp_valid_o, ras_o, cas_o, pre_o}), 0);
    do_req(0, 5, 0, "");       // R3
    do_req(0, 6, 0, "");       // R4
    do_req(1, 7, 8'hA5, "");   // R6 hit write
    do_req(0, 7, 0, "");
    do_req(0, 14, 0, "");      // R5
    do_req(1, 0, 8'h3C, "");
    do_req(0, 0, 0, "");
    for (int a = 0; a < 16; a++) do_req(0, a, 0, "");
    // R9: refresh closes the open row
    do_req(0, 9, 0, "");
    begin
      int r0 = ref_cnt;
      while (ref_cnt == r0) @(negedge clk);
    end
    do_req(0, 9, 0, "R9 after refresh");
    for (int n = 0; n < 400; n++) begin
      int a = int'($urandom_range(15, 0));
      if (n % 3 == 0) a = (m_row << 2) | int'($urandom_range(3, 0));
      do_req(bit'($urandom_range(1, 0)), a, int'($urandom_range(255, 0)), "");
    end
    chk(ref_cnt >= 4, "R8 refresh count", ref_cnt, 4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 200000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule